// File: doc/BRIEF.md
# Parallel Flash Write Sequencer with Toggle Polling

This block sits on the host side of an asynchronous parallel NOR-style flash bus. It turns one request into a full write operation: a word program, a sector erase, a block erase or a whole-chip erase. The request carries an operation code, an address and a data word. The sequencer plays out the unlock write cycles that the flash needs, using strobe widths set from nanosecond parameters and the clock period. It then reads the target location over and over until the operation has finished.

Completion is judged from bit 6 of the read word. This bit flips on every read while the flash is busy. The sequencer reports success only after four reads in a row show the same bit 6: one pair to detect the end, then two more reads to confirm it. This guards against a poll that lands on the moment the operation completes. If that rule is not met within a read budget set for each operation type, the operation ends with an error flag.

The flash data pins are brought out as an output word, a drive enable and an input word, so that the pad ring can build the bidirectional buffer.

Top module: `nvm_write_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next cycle. The end of the operation is shown by a single-cycle `done_valid` pulse, with `done_err` valid alongside it. `req_ready` is high again in the cycle after that pulse.
- R2: Operation code 0 (program) issues exactly four writes, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R3: Every erase issues six writes. The first five are 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh and 2AAAh/55h. The sixth depends on the code: code 3 (chip) writes 10h to 5555h; code 1 (sector) writes 30h to the request address with its low SECT_LSB bits cleared; code 2 (block) writes 50h to the request address with its low BLK_LSB bits cleared.
- R4: During each write, chip enable is low and write enable is low for at least ceil(WE_LOW_NS/CLK_PERIOD_NS) cycles. Write enable stays high for at least ceil(WE_HIGH_NS/CLK_PERIOD_NS) cycles between two writes. Output enable is high whenever write enable is low.
- R5: Each poll read drives chip enable and output enable low, with write enable high, at the request address. The data word is taken after output enable has been low for ceil(RD_ACCESS_NS/CLK_PERIOD_NS) cycles.
- R6: After the last write, the block reads until four consecutive reads return the same value of data bit 6. It then reports done with `done_err` = 0. The number of reads equals the index of the fourth matching read plus one.
- R7: The data bus drive enable is low in the cycle before output enable falls. It is never high while output enable is low.
- R8: If the confirmation rule of R6 is not met by the read whose count reaches the limit for the operation (TMO_PROG, TMO_SECT, TMO_BLK or TMO_CHIP), the block reports done with `done_err` = 1 after exactly that many reads.
- R9: A mismatch of bit 6 in either confirmation read discards the run. The mismatching read starts a new run, and done is not reported on that read.
- R10: A request offered while an operation is running is ignored. No extra bus writes result, and `req_ready` stays low until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| done_valid | output | 1 | One-cycle end-of-operation pulse |
| done_err | output | 1 | Operation ended by timeout |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for the data pads |
| fl_dq_i | input | DW | Data returned from the flash pads |

## Verification
A fault in the step counter or the command table shows up on the address and data of a write. That write is the fourth or sixth for the final command, and the error appears within a few tens of cycles of the request. A fault in the bus-cycle phase logic shows up as a short strobe, or as a drive enable overlapping a read. It is visible in the first bus cycle after the fault. A fault in the poll judge does not corrupt any pin value. It shows only as the wrong number of output-enable pulses before `done_valid`, or as the wrong `done_err`. For that reason the bench feeds each operation a scripted sequence of bit-6 values and counts the reads exactly.

// File: rtl/nvmws_pkg.sv
package nvmws_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } nvm_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WLOW,
    PH_WHIGH,
    PH_RTURN,
    PH_RACC,
    PH_RREC
  } bus_ph_e;

  localparam logic [31:0] UNLK_HI = 32'h0000_5555;
  localparam logic [31:0] UNLK_LO = 32'h0000_2AAA;

  // round a duration up to whole clock cycles, never below one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [2:0] seq_len(input nvm_op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  function automatic logic [31:0] clear_low(input logic [31:0] a, input int lsb);
    return a & ~((32'd1 << lsb) - 32'd1);
  endfunction

  function automatic logic [31:0] seq_addr(input nvm_op_e op, input logic [2:0] idx,
                                           input logic [31:0] tgt, input int sect_lsb,
                                           input int blk_lsb);
    logic [31:0] r;
    case (idx)
      3'd1, 3'd4: r = UNLK_LO;
      3'd3:       r = (op == OP_PROG) ? tgt : UNLK_HI;
      3'd5: begin
        case (op)
          OP_SECT: r = clear_low(tgt, sect_lsb);
          OP_BLK:  r = clear_low(tgt, blk_lsb);
          default: r = UNLK_HI;
        endcase
      end
      default:    r = UNLK_HI;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] seq_data(input nvm_op_e op, input logic [2:0] idx,
                                           input logic [31:0] wdata);
    logic [31:0] r;
    case (idx)
      3'd0:    r = 32'h0000_00AA;
      3'd1:    r = 32'h0000_0055;
      3'd2:    r = (op == OP_PROG) ? 32'h0000_00A0 : 32'h0000_0080;
      3'd3:    r = (op == OP_PROG) ? wdata : 32'h0000_00AA;
      3'd4:    r = 32'h0000_0055;
      default: begin
        case (op)
          OP_SECT: r = 32'h0000_0030;
          OP_BLK:  r = 32'h0000_0050;
          default: r = 32'h0000_0010;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nvmws_bus_engine.sv
module nvmws_bus_engine
  import nvmws_pkg::*;
#(
  parameter int AW          = 19,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 8,
  parameter int RD_CYC      = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_rd,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [DW-1:0] bus_dq_i,
  output logic          cyc_done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_word
);

  localparam int MAXC = max_of4(WE_LOW_CYC, WE_HIGH_CYC, RD_CYC, 1);
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  bus_ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_word <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (go) begin
            addr_q <= go_addr;
            data_q <= go_data;
            ph_q   <= go_rd ? PH_RTURN : PH_WSET;
          end
        end
        PH_WSET: begin
          ph_q  <= PH_WLOW;
          cnt_q <= CW'(WE_LOW_CYC - 1);
        end
        PH_WLOW: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_WHIGH;
            cnt_q <= CW'(WE_HIGH_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_WHIGH: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_RTURN: begin
          ph_q  <= PH_RACC;
          cnt_q <= CW'(RD_CYC - 1);
        end
        PH_RACC: begin
          if (cnt_q == '0) begin
            rd_word <= bus_dq_i;
            ph_q    <= PH_RREC;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RREC: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // pins decoded from the registered phase
  assign bus_ce_n  = !(ph_q inside {PH_WSET, PH_WLOW, PH_WHIGH, PH_RTURN, PH_RACC});
  assign bus_we_n  = (ph_q != PH_WLOW);
  assign bus_oe_n  = (ph_q != PH_RACC);
  assign bus_dq_oe = (ph_q inside {PH_WSET, PH_WLOW, PH_WHIGH});
  assign bus_addr  = addr_q;
  assign bus_dq_o  = data_q;

  assign cyc_done = ((ph_q == PH_WHIGH) && (cnt_q == '0)) || (ph_q == PH_RREC);
  assign rd_valid = (ph_q == PH_RREC);

endmodule

// File: rtl/nvmws_poll_judge.sv
module nvmws_poll_judge #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp,
  input  logic          bit_in,
  input  logic [TW-1:0] limit,
  output logic          confirmed,
  output logic          expired
);

  logic          have_q;
  logic          prev_q;
  logic [1:0]    agree_q;
  logic [TW-1:0] reads_q;
  logic          same;

  assign same = have_q && (bit_in == prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
      agree_q <= '0;
      reads_q <= '0;
    end else if (clr) begin
      have_q  <= 1'b0;
      agree_q <= '0;
      reads_q <= '0;
    end else if (smp) begin
      reads_q <= reads_q + 1'b1;
      if (!have_q) begin
        have_q  <= 1'b1;
        prev_q  <= bit_in;
        agree_q <= '0;
      end else if (same) begin
        agree_q <= (agree_q == 2'd3) ? agree_q : agree_q + 1'b1;
      end else begin
        prev_q  <= bit_in;
        agree_q <= '0;
      end
    end
  end

  // pair found earlier, this sample is the second confirming read
  assign confirmed = smp && same && (agree_q == 2'd2);
  assign expired   = smp && ((TW+1)'(reads_q) + (TW+1)'(1) >= (TW+1)'(limit));

endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
  import nvmws_pkg::*;
#(
  parameter int AW            = 19,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int WE_LOW_NS     = 50,
  parameter int WE_HIGH_NS    = 30,
  parameter int RD_ACCESS_NS  = 70,
  parameter int SECT_LSB      = 11,
  parameter int BLK_LSB       = 15,
  parameter int POLL_BIT      = 6,
  parameter int TMO_PROG      = 4096,
  parameter int TMO_SECT      = 65536,
  parameter int TMO_BLK       = 65536,
  parameter int TMO_CHIP      = 262144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done_valid,
  output logic          done_err,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);

  localparam int WE_LOW_CYC  = ns_to_cycles(WE_LOW_NS, CLK_PERIOD_NS);
  localparam int WE_HIGH_CYC = ns_to_cycles(WE_HIGH_NS, CLK_PERIOD_NS);
  localparam int RD_CYC      = ns_to_cycles(RD_ACCESS_NS, CLK_PERIOD_NS);
  localparam int TMO_MAX     = max_of4(TMO_PROG, TMO_SECT, TMO_BLK, TMO_CHIP);
  localparam int TW          = $clog2(TMO_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_FIN} seq_st_e;

  seq_st_e       st_q;
  nvm_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step_q;
  logic          err_q;

  // named internal events
  logic          accept;
  logic          last_write;
  logic          cyc_done;
  logic          rd_valid;
  logic [DW-1:0] rd_word;
  logic          poll_ok;
  logic          poll_tmo;
  logic [TW-1:0] tmo_limit;
  logic [31:0]   cmd_a32;
  logic [31:0]   cmd_d32;
  logic          eng_go;
  logic          eng_rd;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_data;

  assign accept     = (st_q == S_IDLE) && req_valid;
  assign last_write = (step_q == seq_len(op_q) - 3'd1);

  assign cmd_a32 = seq_addr(op_q, step_q, 32'(addr_q), SECT_LSB, BLK_LSB);
  assign cmd_d32 = seq_data(op_q, step_q, 32'(data_q));

  always_comb begin
    case (op_q)
      OP_PROG: tmo_limit = TW'(TMO_PROG);
      OP_SECT: tmo_limit = TW'(TMO_SECT);
      OP_BLK:  tmo_limit = TW'(TMO_BLK);
      default: tmo_limit = TW'(TMO_CHIP);
    endcase
  end

  assign eng_go   = (st_q == S_WR) || (st_q == S_RD);
  assign eng_rd   = (st_q == S_RD);
  assign eng_addr = eng_rd ? addr_q : cmd_a32[AW-1:0];
  assign eng_data = cmd_d32[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            op_q   <= nvm_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
            st_q   <= S_WR;
          end
        end
        S_WR: begin
          if (cyc_done) begin
            if (last_write) st_q <= S_RD;
            else            step_q <= step_q + 3'd1;
          end
        end
        S_RD: begin
          if (cyc_done && rd_valid) begin
            if (poll_ok) begin
              err_q <= 1'b0;
              st_q  <= S_FIN;
            end else if (poll_tmo) begin
              err_q <= 1'b1;
              st_q  <= S_FIN;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign done_valid = (st_q == S_FIN);
  assign done_err   = err_q;

  nvmws_bus_engine #(
    .AW(AW), .DW(DW),
    .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .RD_CYC(RD_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .go(eng_go), .go_rd(eng_rd), .go_addr(eng_addr), .go_data(eng_data),
    .bus_ce_n(fl_ce_n), .bus_we_n(fl_we_n), .bus_oe_n(fl_oe_n),
    .bus_addr(fl_addr), .bus_dq_o(fl_dq_o), .bus_dq_oe(fl_dq_oe), .bus_dq_i(fl_dq_i),
    .cyc_done(cyc_done), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  nvmws_poll_judge #(.TW(TW)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .clr(accept),
    .smp((st_q == S_RD) && rd_valid),
    .bit_in(rd_word[POLL_BIT]),
    .limit(tmo_limit),
    .confirmed(poll_ok),
    .expired(poll_tmo)
  );

endmodule

// File: rtl/nvmws_checker.sv
module nvmws_checker #(
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done_valid,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);

  logic [7:0] lo_run;
  logic [7:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= 8'hFF;
    end else if (!we_n) begin
      lo_run <= (lo_run == 8'hFF) ? lo_run : lo_run + 8'd1;
      hi_run <= '0;
    end else begin
      lo_run <= '0;
      hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;
    end
  end

  a_r1_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n && !dq_oe));

  a_r4_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (int'(lo_run) >= WE_LOW_CYC));

  a_r4_we_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (int'(hi_run) >= WE_HIGH_CYC));

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  a_r5_read_selects_chip: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  a_r7_released_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe));

  a_r7_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);

endmodule

bind nvm_write_seq nvmws_checker #(
  .WE_LOW_CYC(WE_LOW_CYC),
  .WE_HIGH_CYC(WE_HIGH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .done_valid(done_valid),
  .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n), .dq_oe(fl_dq_oe)
);

// File: tb/nvm_write_seq_tb_top.sv
module nvm_write_seq_tb_top;

  localparam int AW = 19;
  localparam int DW = 16;
  localparam int PER_NS = 4;
  localparam int LOW_MIN  = (50 + PER_NS - 1) / PER_NS;
  localparam int HIGH_MIN = (30 + PER_NS - 1) / PER_NS;

  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] addr;
    logic [15:0] data;
    logic [31:0] pat;
    logic [7:0]  nrd;
    logic        err;
  } vec_t;

  // op, address, data, bit-6 script per read, expected reads, expected error
  localparam vec_t VECS [7] = '{
    '{2'd0, 19'h12345, 16'hBEEF, 32'h0000_002A, 8'd10, 1'b0},
    '{2'd1, 19'h4A9C3, 16'h0000, 32'h0000_0015, 8'd9,  1'b0},
    '{2'd2, 19'h3F0F0, 16'h0000, 32'h0000_0007, 8'd7,  1'b0},
    '{2'd3, 19'h00077, 16'h0000, 32'h5555_5555, 8'd35, 1'b0},
    '{2'd0, 19'h7FFFF, 16'h0001, 32'h5555_5555, 8'd20, 1'b1},
    '{2'd0, 19'h00000, 16'h1234, 32'h0000_0000, 8'd4,  1'b0},
    '{2'd1, 19'h00800, 16'h0000, 32'hAAAA_AAAA, 8'd24, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          done_valid;
  logic          done_err;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o;
  logic [DW-1:0] fl_dq_i;

  always #2 clk = ~clk;

  nvm_write_seq #(
    .AW(AW), .DW(DW), .CLK_PERIOD_NS(PER_NS),
    .TMO_PROG(20), .TMO_SECT(24), .TMO_BLK(24), .TMO_CHIP(40)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .done_valid(done_valid), .done_err(done_err),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model state
  logic [31:0]   pat_q = '0;
  logic [AW-1:0] poll_addr = '0;
  int            rd_cnt = 0;
  int            rd_cur = 0;
  int            wr_cnt = 0;
  int            bad_rd = 0;
  logic [AW-1:0] wr_a [8];
  logic [DW-1:0] wr_d [8];
  int            lo_run = 0, hi_run = 0, min_lo = 1000, min_hi = 1000;
  bit            seen_wr = 0;

  assign fl_dq_i = (!fl_oe_n && !fl_ce_n) ?
                   {9'h0, ((rd_cur < 32) ? pat_q[rd_cur] : 1'b0), 6'h3F} : '0;

  always @(posedge fl_we_n) begin
    if (fl_ce_n === 1'b0) begin
      if (wr_cnt < 8) begin
        wr_a[wr_cnt] = fl_addr;
        wr_d[wr_cnt] = fl_dq_o;
      end
      wr_cnt++;
    end
  end

  always @(negedge fl_oe_n) begin
    if (fl_ce_n !== 1'b0 || fl_dq_oe !== 1'b0 || fl_we_n !== 1'b1 || fl_addr !== poll_addr)
      bad_rd++;
    rd_cur = rd_cnt;
    rd_cnt++;
  end

  always @(negedge clk) begin
    if (fl_we_n === 1'b0) begin
      if (lo_run == 0 && seen_wr && hi_run < min_hi) min_hi = hi_run;
      lo_run++;
      hi_run = 0;
    end else begin
      if (lo_run > 0) begin
        if (lo_run < min_lo) min_lo = lo_run;
        seen_wr = 1;
      end
      lo_run = 0;
      hi_run++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  function automatic void exp_wr(input logic [1:0] op, input int i, input logic [18:0] a,
                                 input logic [15:0] d, output logic [18:0] ea,
                                 output logic [15:0] ed);
    logic [18:0] pa [4] = '{19'h5555, 19'h2AAA, 19'h5555, 19'h0};
    logic [7:0]  pd [4] = '{8'hAA, 8'h55, 8'hA0, 8'h00};
    logic [18:0] xa [6] = '{19'h5555, 19'h2AAA, 19'h5555, 19'h5555, 19'h2AAA, 19'h5555};
    logic [7:0]  xd [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    if (op == 2'd0) begin
      ea = (i == 3) ? a : pa[i];
      ed = (i == 3) ? d : {8'h00, pd[i]};
    end else begin
      ea = xa[i];
      ed = {8'h00, xd[i]};
      if (i == 5 && op == 2'd1) begin ea = {a[18:11], 11'h0}; ed = 16'h0030; end
      if (i == 5 && op == 2'd2) begin ea = {a[18:15], 15'h0}; ed = 16'h0050; end
    end
  endfunction

  task automatic model_clear(input logic [31:0] pat, input logic [18:0] a);
    pat_q = pat; poll_addr = a;
    rd_cnt = 0; rd_cur = 0; wr_cnt = 0; bad_rd = 0;
    min_lo = 1000; min_hi = 1000; seen_wr = 0;
  endtask

  task automatic wait_done(output logic err);
    int w = 0;
    while (!done_valid && w < 20000) begin @(negedge clk); w++; end
    err = done_err;
    check(done_valid == 1'b1, "R1 done seen", done_valid, 1);
    @(negedge clk);
    check(!done_valid && req_ready, "R1 done single pulse, ready back",
          {done_valid, req_ready}, 2'b01);
  endtask

  task automatic run_vec(input vec_t v, input int k);
    logic err;
    logic [18:0] ea;
    logic [15:0] ed;
    int nw;
    model_clear(v.pat, v.addr);
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1 ready drops after take", req_ready, 0);
    wait_done(err);
    nw = (v.op == 2'd0) ? 4 : 6;
    check(wr_cnt == nw, (v.op == 2'd0) ? "R2 write count" : "R3 write count", wr_cnt, nw);
    for (int i = 0; i < nw && i < wr_cnt; i++) begin
      exp_wr(v.op, i, v.addr, v.data, ea, ed);
      check(wr_a[i] == ea && wr_d[i] == ed, (v.op == 2'd0) ? "R2 write pair" : "R3 write pair",
            {wr_a[i], wr_d[i]}, {ea, ed});
    end
    check(min_lo >= LOW_MIN, "R4 we low width", min_lo, LOW_MIN);
    check(min_hi >= HIGH_MIN, "R4 we high width", min_hi, HIGH_MIN);
    check(bad_rd == 0, "R5 R7 read cycle pins", bad_rd, 0);
    if (v.err) check(rd_cnt == int'(v.nrd), "R8 reads to timeout", rd_cnt, v.nrd);
    else if (k == 2) check(rd_cnt == int'(v.nrd), "R9 restart after mismatch", rd_cnt, v.nrd);
    else check(rd_cnt == int'(v.nrd), "R6 reads to confirm", rd_cnt, v.nrd);
    check(err == v.err, v.err ? "R8 error flag" : "R6 no error", err, v.err);
  endtask

  initial begin
    logic err;
    repeat (3) @(negedge clk);
    check(req_ready && !done_valid && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe,
          "R1 reset state", {req_ready, done_valid, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe},
          6'b101110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 7; k++) run_vec(VECS[k], k);

    // R10: a second request during a running program is ignored
    model_clear(32'h0, 19'h01010);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h01010; req_data = 16'hA5A5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h00000;
    repeat (5) begin
      @(negedge clk);
      check(!req_ready, "R10 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_done(err);
    check(wr_cnt == 4, "R10 no extra writes", wr_cnt, 4);
    check(rd_cnt == 4 && !err, "R10 original op completes", rd_cnt, 4);
    repeat (20) @(negedge clk);
    check(wr_cnt == 4 && rd_cnt == 4, "R10 bus stays quiet after", wr_cnt + rd_cnt, 8);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule